// File: doc/BRIEF.md
# Partitioned Bucket Receive Buffer

This block is the receive-side message store of one station on a ring where senders hold credits. A single 256-entry message memory is divided by configuration into up to eight buckets. Each bucket gets its own contiguous region, and each region behaves as its own circular queue. An arriving message names a bucket and is appended to that bucket's region. A local consumer pulls the oldest message from a bucket it selects.

Every message that is pulled out leaves the block one cycle later. It carries its bucket number and the identity of its original sender, so the surrounding logic can return one credit to that sender. Software sets each bucket's size through a small configuration port. The block reports per-bucket empty and full levels, sticky per-bucket overflow flags and a configuration-error flag.

Top module: `bucket_rx_store`

## Requirements
- R1: After reset every bucket has size zero, `emptyMask` and `fullMask` are all ones, `ovflErr` is all zeros, `cfgErr` is 0 and `outValid` is 0.
- R2: Messages written to one bucket come out of that bucket in arrival order. An accepted read (`rdEn` on a non-empty bucket) makes `outValid` high at the next clock edge, together with that entry's `outBucket`, `outSender` and `outData`.
- R3: Bucket regions lie back to back: a bucket's first entry is the sum of the sizes of all lower-numbered buckets. Each bucket wraps inside its own region, and traffic to one bucket never alters the contents of another.
- R4: A write to a bucket of size zero is dropped and sets that bucket's bit in `ovflErr`.
- R5: A write to a full bucket, without a read of the same bucket in the same cycle, is dropped and sets that bucket's `ovflErr` bit. The bit stays set until reset, and the stored contents of the bucket are unchanged.
- R6: `cfgErr` is 1 while the sizes add up to more than 256. A total of exactly 256 is legal.
- R7: `cfgErr` is also 1 while any nonzero size is not a power of two, or while any nonzero size does not evenly divide that bucket's start index. While `cfgErr` is 1, every write is dropped and `ovflErr` does not change.
- R8: A write and an accepted read of the same bucket in one cycle both take effect. The occupancy of that bucket, and with it `emptyMask` and `fullMask`, stays the same. This holds even when the bucket is full, and the read returns the older entry.
- R9: `rdEn` on an empty bucket is ignored: `outValid` stays 0 and no state changes.
- R10: A configuration write (`cfgWe`) sets the size of `cfgBucket` and empties every bucket. Data writes and reads in that same cycle are ignored.
- R11: `outValid` is a single-cycle pulse per accepted read. It doubles as the credit return for the sender and bucket it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgBucket | input | 3 | Bucket whose size is written |
| cfgSize | input | 9 | New size in entries (0 to 256) |
| wrValid | input | 1 | Incoming message strobe |
| wrBucket | input | 3 | Target bucket of the incoming message |
| wrSender | input | 4 | Sender identity stored with the message |
| wrData | input | 32 | Message payload |
| rdEn | input | 1 | Dequeue request |
| rdBucket | input | 3 | Bucket to dequeue from |
| outValid | output | 1 | Dequeued message and credit-return pulse |
| outBucket | output | 3 | Bucket the message came from |
| outSender | output | 4 | Sender to be credited |
| outData | output | 32 | Dequeued payload |
| emptyMask | output | 8 | Per-bucket empty level |
| fullMask | output | 8 | Per-bucket full level (size reached; size-zero buckets read full) |
| ovflErr | output | 8 | Per-bucket sticky overflow flags |
| cfgErr | output | 1 | Current size configuration is illegal |

## Verification
The hardest situation to reach from the ports is a full bucket whose tail has wrapped onto its head, hit by a write and a read in the same cycle. Only there do the two memory accesses land on the same entry. The stimulus first fills and drains a four-entry bucket so that its pointers sit mid-region. It then refills the bucket to the brim and issues the combined write and read. It drains the bucket afterwards, and the scoreboard confirms that the old entry came out first and that the new one arrived last. The misaligned and over-committed layouts are reached with single size writes on top of a legal 256-entry layout.

// File: rtl/bucket_rx_pkg.sv
package bucket_rx_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } strb_t;

endpackage

// File: rtl/bucket_rx_ctrl.sv
module bucket_rx_ctrl
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int NUM_BKT = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int BKT_W  = $clog2(NUM_BKT),
  localparam int SUM_W  = CNT_W + BKT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [BKT_W-1:0]   cfgBucket,
  input  logic [CNT_W-1:0]   cfgSize,
  input  logic               wrValid,
  input  logic [BKT_W-1:0]   wrBucket,
  input  logic               rdEn,
  input  logic [BKT_W-1:0]   rdBucket,
  output strb_t              strb,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_BKT-1:0] emptyMask,
  output logic [NUM_BKT-1:0] fullMask,
  output logic [NUM_BKT-1:0] ovflErr,
  output logic               cfgErr
);

  logic [CNT_W-1:0] bktSize [NUM_BKT];
  logic [CNT_W-1:0] headOff [NUM_BKT];
  logic [CNT_W-1:0] tailOff [NUM_BKT];
  logic [CNT_W-1:0] bktCnt  [NUM_BKT];
  logic [SUM_W-1:0] startIdx [NUM_BKT];
  logic             badCfg;
  logic             deqOk, enqOk, dropWr;

  function automatic logic [CNT_W-1:0] nextOff(input logic [CNT_W-1:0] off,
                                               input logic [CNT_W-1:0] sz);
    return (off + 1'b1 == sz) ? '0 : off + 1'b1;
  endfunction

  // Region layout and legality of the size set
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc    = '0;
    badCfg = 1'b0;
    for (int b = 0; b < NUM_BKT; b++) begin
      startIdx[b] = acc;
      if (bktSize[b] != '0) begin
        if ((bktSize[b] & (bktSize[b] - 1'b1)) != '0) badCfg = 1'b1;
        if ((acc & SUM_W'(bktSize[b] - 1'b1)) != '0) badCfg = 1'b1;
      end
      acc = acc + SUM_W'(bktSize[b]);
    end
    if (acc > SUM_W'(DEPTH)) badCfg = 1'b1;
  end

  assign cfgErr = badCfg;

  for (genvar g = 0; g < NUM_BKT; g++) begin : gLevel
    assign emptyMask[g] = (bktCnt[g] == '0);
    assign fullMask[g]  = (bktCnt[g] == bktSize[g]);
  end

  // Accept decisions
  assign deqOk  = !cfgWe && rdEn && !emptyMask[rdBucket];
  assign enqOk  = !cfgWe && wrValid && !badCfg && (bktSize[wrBucket] != '0) &&
                  (!fullMask[wrBucket] || (deqOk && rdBucket == wrBucket));
  assign dropWr = !cfgWe && wrValid && !badCfg && !enqOk;

  assign strb.wrEn = enqOk;
  assign strb.rdEn = deqOk;
  assign wrAddr = ADDR_W'(startIdx[wrBucket] + SUM_W'(tailOff[wrBucket]));
  assign rdAddr = ADDR_W'(startIdx[rdBucket] + SUM_W'(headOff[rdBucket]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovflErr <= '0;
      for (int b = 0; b < NUM_BKT; b++) begin
        bktSize[b] <= '0;
        headOff[b] <= '0;
        tailOff[b] <= '0;
        bktCnt[b]  <= '0;
      end
    end else if (cfgWe) begin
      bktSize[cfgBucket] <= cfgSize;
      for (int b = 0; b < NUM_BKT; b++) begin
        headOff[b] <= '0;
        tailOff[b] <= '0;
        bktCnt[b]  <= '0;
      end
    end else begin
      if (dropWr) ovflErr[wrBucket] <= 1'b1;
      for (int b = 0; b < NUM_BKT; b++) begin
        logic inc, dec;
        inc = enqOk && (wrBucket == BKT_W'(b));
        dec = deqOk && (rdBucket == BKT_W'(b));
        if (inc) tailOff[b] <= nextOff(tailOff[b], bktSize[b]);
        if (dec) headOff[b] <= nextOff(headOff[b], bktSize[b]);
        if (inc && !dec)      bktCnt[b] <= bktCnt[b] + 1'b1;
        else if (dec && !inc) bktCnt[b] <= bktCnt[b] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bucket_rx_dp.sv
module bucket_rx_dp
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int NUM_BKT  = 8,
  parameter int SENDER_W = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int BKT_W   = $clog2(NUM_BKT),
  localparam int WORD_W  = SENDER_W + DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strb_t               strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [BKT_W-1:0]    rdBucket,
  input  logic [SENDER_W-1:0] wrSender,
  input  logic [DATA_W-1:0]   wrData,
  output logic                outValid,
  output logic [BKT_W-1:0]    outBucket,
  output logic [SENDER_W-1:0] outSender,
  output logic [DATA_W-1:0]   outData
);

  logic [WORD_W-1:0] msgMem [DEPTH];
  logic [WORD_W-1:0] outWord;

  // Read sees the old word when both ports hit one entry
  always_ff @(posedge clk) begin
    if (strb.wrEn) msgMem[wrAddr] <= {wrSender, wrData};
    if (strb.rdEn) outWord <= msgMem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outBucket <= '0;
    end else begin
      outValid <= strb.rdEn;
      if (strb.rdEn) outBucket <= rdBucket;
    end
  end

  assign outSender = outWord[WORD_W-1:DATA_W];
  assign outData   = outWord[DATA_W-1:0];

endmodule

// File: rtl/bucket_rx_store.sv
module bucket_rx_store
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int NUM_BKT  = 8,
  parameter int SENDER_W = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = ADDR_W + 1,
  localparam int BKT_W   = $clog2(NUM_BKT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [BKT_W-1:0]    cfgBucket,
  input  logic [CNT_W-1:0]    cfgSize,
  input  logic                wrValid,
  input  logic [BKT_W-1:0]    wrBucket,
  input  logic [SENDER_W-1:0] wrSender,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [BKT_W-1:0]    rdBucket,
  output logic                outValid,
  output logic [BKT_W-1:0]    outBucket,
  output logic [SENDER_W-1:0] outSender,
  output logic [DATA_W-1:0]   outData,
  output logic [NUM_BKT-1:0]  emptyMask,
  output logic [NUM_BKT-1:0]  fullMask,
  output logic [NUM_BKT-1:0]  ovflErr,
  output logic                cfgErr
);

  strb_t             strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  bucket_rx_ctrl #(.DEPTH(DEPTH), .NUM_BKT(NUM_BKT)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBucket(cfgBucket), .cfgSize(cfgSize),
    .wrValid(wrValid), .wrBucket(wrBucket), .rdEn(rdEn), .rdBucket(rdBucket),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .emptyMask(emptyMask),
    .fullMask(fullMask), .ovflErr(ovflErr), .cfgErr(cfgErr)
  );

  bucket_rx_dp #(.DEPTH(DEPTH), .NUM_BKT(NUM_BKT), .SENDER_W(SENDER_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdBucket(rdBucket), .wrSender(wrSender), .wrData(wrData), .outValid(outValid),
    .outBucket(outBucket), .outSender(outSender), .outData(outData)
  );

endmodule

// File: rtl/bucket_rx_chk.sv
module bucket_rx_chk #(
  parameter int NUM_BKT = 8,
  localparam int BKT_W  = $clog2(NUM_BKT)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic               wrValid,
  input logic [BKT_W-1:0]   wrBucket,
  input logic               rdEn,
  input logic [BKT_W-1:0]   rdBucket,
  input logic               outValid,
  input logic [NUM_BKT-1:0] emptyMask,
  input logic [NUM_BKT-1:0] fullMask,
  input logic [NUM_BKT-1:0] ovflErr,
  input logic               cfgErr
);

  AST_OUT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(rdEn) && !$past(cfgWe) && !$past(emptyMask[rdBucket]))); // R11

  AST_EMPTY_READ_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && emptyMask[rdBucket]) |=> !outValid); // R9

  AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(ovflErr) & ~ovflErr) == '0)); // R5

  AST_CFGERR_NO_OVFL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !cfgWe) |=> (ovflErr == $past(ovflErr))); // R7

  AST_SIMUL_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdEn && wrBucket == rdBucket && !emptyMask[rdBucket] && !cfgWe && !cfgErr)
    |=> (fullMask == $past(fullMask) && emptyMask == $past(emptyMask))); // R8

endmodule

bind bucket_rx_store bucket_rx_chk #(.NUM_BKT(NUM_BKT)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .wrValid(wrValid), .wrBucket(wrBucket),
  .rdEn(rdEn), .rdBucket(rdBucket), .outValid(outValid), .emptyMask(emptyMask),
  .fullMask(fullMask), .ovflErr(ovflErr), .cfgErr(cfgErr)
);

// File: tb/bucket_rx_store_test.sv
module bucket_rx_store_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgBucket = '0;
  logic [8:0]  cfgSize = '0;
  logic        wrValid = 1'b0;
  logic [2:0]  wrBucket = '0;
  logic [3:0]  wrSender = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdBucket = '0;
  logic        outValid;
  logic [2:0]  outBucket;
  logic [3:0]  outSender;
  logic [31:0] outData;
  logic [7:0]  emptyMask, fullMask, ovflErr;
  logic        cfgErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Bench model, built from the requirements
  int          mSize [8];
  logic [35:0] mQ [8][$];
  logic [7:0]  mOvfl = '0;
  logic [38:0] expQ [$];

  always #5 clk = ~clk;

  bucket_rx_store uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBucket(cfgBucket), .cfgSize(cfgSize),
    .wrValid(wrValid), .wrBucket(wrBucket), .wrSender(wrSender), .wrData(wrData),
    .rdEn(rdEn), .rdBucket(rdBucket), .outValid(outValid), .outBucket(outBucket),
    .outSender(outSender), .outData(outData), .emptyMask(emptyMask),
    .fullMask(fullMask), .ovflErr(ovflErr), .cfgErr(cfgErr)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit cfgBad();
    int acc = 0;
    bit bad = 0;
    for (int b = 0; b < 8; b++) begin
      if (mSize[b] != 0) begin
        if ((mSize[b] & (mSize[b] - 1)) != 0) bad = 1;
        if ((acc % mSize[b]) != 0) bad = 1;
      end
      acc += mSize[b];
    end
    if (acc > 256) bad = 1;
    return bad;
  endfunction

  task automatic chkLevels(string req);
    logic [7:0] expE, expF;
    for (int b = 0; b < 8; b++) begin
      expE[b] = (mQ[b].size() == 0);
      expF[b] = (mQ[b].size() == mSize[b]);
    end
    chk(emptyMask == expE, req, "emptyMask", emptyMask, expE);
    chk(fullMask == expF, req, "fullMask", fullMask, expF);
    chk(ovflErr == mOvfl, req, "ovflErr", ovflErr, mOvfl);
    chk(cfgErr == cfgBad(), req, "cfgErr", cfgErr, cfgBad());
  endtask

  // Driver: one cycle of write and/or read, expectations pushed to the scoreboard
  task automatic step(bit w, int wb, int ws, int wd, bit r, int rb);
    bit popped = 0;
    wrValid = w; wrBucket = 3'(wb); wrSender = 4'(ws); wrData = 32'(wd);
    rdEn = r; rdBucket = 3'(rb);
    if (r && mQ[rb].size() > 0) begin
      expQ.push_back({3'(rb), mQ[rb].pop_front()});
      popped = 1;
    end
    if (w && !cfgBad()) begin
      if (mSize[wb] != 0 && (mQ[wb].size() < mSize[wb] || (popped && rb == wb)))
        mQ[wb].push_back({4'(ws), 32'(wd)});
      else
        mOvfl[wb] = 1'b1;
    end
    @(negedge clk);
    wrValid = 1'b0; rdEn = 1'b0;
  endtask

  task automatic push(int b, int s, int d); step(1, b, s, d, 0, 0); endtask
  task automatic pop(int b); step(0, 0, 0, 0, 1, b); endtask

  task automatic cfg(int b, int s);
    cfgWe = 1'b1; cfgBucket = 3'(b); cfgSize = 9'(s);
    mSize[b] = s;
    for (int i = 0; i < 8; i++) mQ[i].delete();
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Monitor: compare every dequeued message against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      if (expQ.size() == 0) begin
        chk(0, "R2", "unexpected outValid", {outBucket, outSender, outData}, 0);
      end else begin
        logic [38:0] e;
        e = expQ.pop_front();
        chk({outBucket, outSender, outData} == e, "R2", "dequeued item",
            {outBucket, outSender, outData}, e);
      end
    end
  end

  initial begin
    #2_000_000;
    chk(0, "R2", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) mSize[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkLevels("R1");
    chk(outValid == 1'b0, "R1", "outValid", outValid, 0);

    // Legal layout totalling exactly 256: 4,4,8,0,16,32,64,128
    cfg(0, 4); cfg(1, 4); cfg(2, 8); cfg(4, 16); cfg(5, 32); cfg(6, 64); cfg(7, 128);
    chkLevels("R6");

    // R2: interleaved buckets, order per bucket
    push(0, 1, 'h100); push(1, 2, 'h200); push(0, 3, 'h101); push(1, 4, 'h201); push(0, 5, 'h102);
    pop(0); pop(1); pop(0); pop(1); pop(0);
    @(negedge clk);
    chkLevels("R2");

    // R5: fill bucket 0, overflow, content untouched
    for (int i = 0; i < 5; i++) push(0, 6, 'h300 + i);
    chkLevels("R5");
    for (int i = 0; i < 4; i++) pop(0);
    @(negedge clk);
    chkLevels("R5");

    // R3: wrap inside bucket 0 while bucket 1 holds data
    push(1, 7, 'h400); push(1, 7, 'h401);
    for (int i = 0; i < 3; i++) push(0, 8, 'h500 + i);
    for (int i = 0; i < 3; i++) pop(0);
    for (int i = 0; i < 4; i++) push(0, 9, 'h510 + i);
    chkLevels("R3");
    for (int i = 0; i < 4; i++) pop(0);
    pop(1); pop(1);
    @(negedge clk);
    chkLevels("R3");

    // R4: zero-size bucket
    push(3, 1, 'h600);
    chkLevels("R4");

    // R9: read of an empty bucket
    pop(2);
    chk(outValid == 1'b0, "R9", "outValid after empty read", outValid, 0);
    chkLevels("R9");

    // R8: simultaneous write and read on a full bucket, then on a partly filled one
    for (int i = 0; i < 4; i++) push(0, 10, 'h700 + i);
    step(1, 0, 11, 'h7ff, 1, 0);
    chkLevels("R8");
    for (int i = 0; i < 4; i++) pop(0);
    push(2, 12, 'h800);
    step(1, 2, 13, 'h801, 1, 2);
    chkLevels("R8");
    pop(2);
    @(negedge clk);

    // R11: single-cycle credit pulse
    push(5, 14, 'h900);
    pop(5);
    chk(outValid == 1'b1, "R11", "pulse high", outValid, 1);
    chk(outBucket == 3'd5, "R11", "credit bucket", outBucket, 5);
    chk(outSender == 4'd14, "R11", "credit sender", outSender, 14);
    @(negedge clk);
    chk(outValid == 1'b0, "R11", "pulse low", outValid, 0);

    // R10: configuration write flushes everything
    push(6, 1, 'ha00); push(6, 1, 'ha01);
    cfg(7, 128);
    chkLevels("R10");
    pop(6);
    chk(outValid == 1'b0, "R10", "outValid after flush", outValid, 0);

    // R6: over-committed memory
    cfg(7, 256);
    chkLevels("R6");
    push(0, 2, 'hb00);
    chkLevels("R7");
    pop(0);
    chk(outValid == 1'b0, "R7", "write blocked", outValid, 0);

    // R7: misaligned start, then non power of two
    cfg(7, 128); cfg(1, 2);
    chkLevels("R7");
    push(2, 3, 'hc00);
    chkLevels("R7");
    cfg(1, 4); cfg(5, 24);
    chkLevels("R7");
    cfg(5, 32);
    push(0, 4, 'hd00);
    pop(0);
    @(negedge clk);
    chkLevels("R7");

    chk(expQ.size() == 0, "R2", "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule